// File: doc/BRIEF.md
# Dual-Port Handshake Mailbox

This block is a register bank shared by two agents: a host processor and an embedded firmware processor. Each agent has its own word-addressed register port. A write takes effect on the clock edge where its strobe is high. Read data appears one cycle after the address is presented. Through the bank the two agents exchange fixed-size messages. They advance two 32-bit handshake words, each packing a request count and an acknowledge count. They take turns owning a shared message buffer.

Ownership works by claim and check. An agent writes its hold bit, then reads its control register back. It owns the buffer only if the bit reads as set. The bank never grants the buffer to both agents at once, and the firmware agent wins a tie. When the host sets its request bit, the bank pulses a doorbell toward the firmware unless a mask bit suppresses it. A host write to the first buffer word marks that the host has finished reading the message, and the bank signals this to the firmware as a one-cycle strobe.

Word map, the same on both ports (byte offset = 4 × word): word 0 is the firmware-to-host handshake word, word 1 is the host-to-firmware handshake word, words 2 to 15 are the 14-word message buffer, word 16 is the agent's own control register and word 17 is the shared mask register. Any other word reads as zero and ignores writes.

Top module: `mbox_bank`

## Requirements
- R1: After a synchronous reset, both handshake words, both control registers, the doorbell and the read-complete strobe are zero, and the mask register holds 0xFFFF0000.
- R2: Word 0 takes writes only from the firmware port and word 1 only from the host port. A write from the other port leaves the word unchanged. Both ports read both words, whose bits 15:0 are the request count and bits 31:16 the acknowledge count.
- R3: A buffer word (words 2 to 15) is written by an agent only while that agent holds the lock. Otherwise the write is ignored. Both ports may read any buffer word at any time.
- R4: A host write to word 16 with bit 3 set grants the host hold only if the firmware does not hold the lock and is not claiming it in the same cycle. Control readback puts the agent's own hold in bit 3, the other agent's hold in bit 4 and the host request in bit 0.
- R5: A firmware write to word 16 with bit 3 set grants the firmware hold unless the host already holds. When both agents claim a free lock in the same cycle, the firmware gets it. The two holds are never set together.
- R6: A write to an agent's control register with bit 3 clear releases that agent's hold. For the host, it also clears the request bit.
- R7: The host request bit (bit 0 of word 16) is stored only together with a granted hold. When it goes from 0 to 1, `fw_doorbell` is high for exactly one cycle, starting one cycle after the write edge. Rewriting a request that is already set gives no pulse.
- R8: Mask bit 0 set suppresses the doorbell. Either port may write the mask, and the firmware write wins on a same-cycle collision.
- R9: A host write to buffer word 2 (byte offset 8) while the host holds the lock raises `fw_rd_done` for one cycle, in the cycle right after the write edge. Writes to other words, or writes without the lock, do not raise it.
- R10: Read data on each port reflects the addressed word one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | AW (5) | Host word address |
| h_wdata | input | DW (32) | Host write data |
| h_rdata | output | DW (32) | Host read data, one cycle latency |
| f_wr | input | 1 | Firmware write strobe |
| f_addr | input | AW (5) | Firmware word address |
| f_wdata | input | DW (32) | Firmware write data |
| f_rdata | output | DW (32) | Firmware read data, one cycle latency |
| fw_doorbell | output | 1 | One-cycle pulse toward firmware on a new host request |
| fw_rd_done | output | 1 | One-cycle strobe when the host marks a message read |

## Verification
The bench makes both agents claim a free lock on the same edge. A design with the wrong priority would hand the buffer to the host, or to both agents. It makes the host claim and request while the firmware owns the buffer. A design that stores the request without a hold would ring the doorbell with nobody owning the buffer. It rewrites a request bit that is already set, and it sets the mask from each port. Level-sensitive or unmasked doorbell logic would produce extra or stray pulses here. It also writes to the buffer and to the wrong-side handshake word without permission and reads the words back through the other port, which exposes any write that should have been dropped. The same test also catches a read-complete strobe raised without the lock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // word indices of the fixed part of the window
  localparam int WORD_F2H  = 0;
  localparam int WORD_H2F  = 1;
  localparam int BUF_BASE  = 2;

  // control register bit positions
  localparam int CTL_REQ  = 0;
  localparam int CTL_HOLD = 3;
  localparam int CTL_PEER = 4;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_F2H,
    RG_H2F,
    RG_BUF,
    RG_CTRL,
    RG_MASK
  } region_e;

  function automatic region_e decode_word(input logic [31:0] a, input int unsigned n);
    region_e r;
    if (a == 32'(WORD_F2H))                           r = RG_F2H;
    else if (a == 32'(WORD_H2F))                      r = RG_H2F;
    else if (a >= 32'(BUF_BASE) && a < 32'(BUF_BASE + n)) r = RG_BUF;
    else if (a == 32'(BUF_BASE + n))                  r = RG_CTRL;
    else if (a == 32'(BUF_BASE + n + 1))              r = RG_MASK;
    else                                              r = RG_NONE;
    return r;
  endfunction

endpackage

// File: rtl/mbox_lock.sv
module mbox_lock (
  input  logic clk,
  input  logic rst,
  input  logic h_ctrl_wr,
  input  logic h_want,
  input  logic h_want_req,
  input  logic f_ctrl_wr,
  input  logic f_want,
  output logic h_hold,
  output logic h_req,
  output logic f_hold
);

  logic f_claim;
  logic h_grant;

  // a firmware claim in the same cycle blocks a new host grant
  assign f_claim = f_ctrl_wr & f_want;
  assign h_grant = h_want & (h_hold | (~f_hold & ~f_claim));

  always_ff @(posedge clk) begin
    if (rst) begin
      h_hold <= 1'b0;
      h_req  <= 1'b0;
      f_hold <= 1'b0;
    end else begin
      if (f_ctrl_wr) f_hold <= f_want & (f_hold | ~h_hold);
      if (h_ctrl_wr) begin
        h_hold <= h_grant;
        h_req  <= h_want_req & h_grant;
      end
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(h_hold && f_hold)); // R5

  AST_FW_WINS: assert property (@(posedge clk) disable iff (rst)
    (h_ctrl_wr && h_want && f_ctrl_wr && f_want && !h_hold && !f_hold)
    |=> (f_hold && !h_hold)); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (h_ctrl_wr && !h_want) |=> (!h_hold && !h_req)); // R6

  AST_REQ_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    h_req |-> h_hold); // R7

endmodule

// File: rtl/mbox_buf.sv
module mbox_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 14,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_h,
  output logic [DW-1:0] rd_h,
  input  logic [IW-1:0] ra_f,
  output logic [DW-1:0] rd_f
);

  // one write port, two registered read ports; no reset on the array
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_h <= mem[ra_h];
    rd_f <= mem[ra_f];
  end

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH)); // R3

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          BUF_WORDS = 14,
  parameter int          AW        = 5,
  parameter logic [31:0] MASK_INIT = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wr,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          f_wr,
  input  logic [AW-1:0] f_addr,
  input  logic [DW-1:0] f_wdata,
  output logic [DW-1:0] f_rdata,
  output logic          fw_doorbell,
  output logic          fw_rd_done
);

  localparam int BIW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  region_e        h_rg, f_rg;
  logic [BIW-1:0] h_bidx, f_bidx;
  logic [DW-1:0]  cnt_f2h_q, cnt_h2f_q, mask_q;
  logic           h_hold, h_req, f_hold;
  logic           h_bw, f_bw, buf_we;
  logic [BIW-1:0] buf_waddr;
  logic [DW-1:0]  buf_wdata;
  logic [DW-1:0]  h_buf_rd, f_buf_rd;
  logic [DW-1:0]  h_ctl_view, f_ctl_view;
  logic [DW-1:0]  h_reg_q, f_reg_q;
  logic           h_isbuf_q, f_isbuf_q;
  logic           h_req_d;

  // ---------------- address decode ----------------
  always_comb begin
    h_rg   = decode_word(32'(h_addr), BUF_WORDS);
    f_rg   = decode_word(32'(f_addr), BUF_WORDS);
    h_bidx = (h_rg == RG_BUF) ? BIW'(h_addr - AW'(BUF_BASE)) : '0;
    f_bidx = (f_rg == RG_BUF) ? BIW'(f_addr - AW'(BUF_BASE)) : '0;
  end

  // ---------------- lock arbitration ----------------
  mbox_lock u_lock (
    .clk        (clk),
    .rst        (rst),
    .h_ctrl_wr  (h_wr && h_rg == RG_CTRL),
    .h_want     (h_wdata[CTL_HOLD]),
    .h_want_req (h_wdata[CTL_REQ]),
    .f_ctrl_wr  (f_wr && f_rg == RG_CTRL),
    .f_want     (f_wdata[CTL_HOLD]),
    .h_hold     (h_hold),
    .h_req      (h_req),
    .f_hold     (f_hold)
  );

  // ---------------- message buffer ----------------
  always_comb begin
    h_bw      = h_wr && (h_rg == RG_BUF) && h_hold;
    f_bw      = f_wr && (f_rg == RG_BUF) && f_hold;
    buf_we    = h_bw || f_bw;
    buf_waddr = f_bw ? f_bidx  : h_bidx;
    buf_wdata = f_bw ? f_wdata : h_wdata;
  end

  mbox_buf #(.DW(DW), .DEPTH(BUF_WORDS)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .ra_h  (h_bidx),
    .rd_h  (h_buf_rd),
    .ra_f  (f_bidx),
    .rd_f  (f_buf_rd)
  );

  // ---------------- handshake words and mask ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_f2h_q <= '0;
      cnt_h2f_q <= '0;
      mask_q    <= DW'(MASK_INIT);
    end else begin
      if (f_wr && f_rg == RG_F2H) cnt_f2h_q <= f_wdata;
      if (h_wr && h_rg == RG_H2F) cnt_h2f_q <= h_wdata;
      if (f_wr && f_rg == RG_MASK)      mask_q <= f_wdata;
      else if (h_wr && h_rg == RG_MASK) mask_q <= h_wdata;
    end
  end

  // ---------------- read paths ----------------
  always_comb begin
    h_ctl_view           = '0;
    h_ctl_view[CTL_REQ]  = h_req;
    h_ctl_view[CTL_HOLD] = h_hold;
    h_ctl_view[CTL_PEER] = f_hold;
    f_ctl_view           = '0;
    f_ctl_view[CTL_REQ]  = h_req;
    f_ctl_view[CTL_HOLD] = f_hold;
    f_ctl_view[CTL_PEER] = h_hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_reg_q   <= '0;
      f_reg_q   <= '0;
      h_isbuf_q <= 1'b0;
      f_isbuf_q <= 1'b0;
    end else begin
      h_isbuf_q <= (h_rg == RG_BUF);
      f_isbuf_q <= (f_rg == RG_BUF);
      unique case (h_rg)
        RG_F2H:  h_reg_q <= cnt_f2h_q;
        RG_H2F:  h_reg_q <= cnt_h2f_q;
        RG_CTRL: h_reg_q <= h_ctl_view;
        RG_MASK: h_reg_q <= mask_q;
        default: h_reg_q <= '0;
      endcase
      unique case (f_rg)
        RG_F2H:  f_reg_q <= cnt_f2h_q;
        RG_H2F:  f_reg_q <= cnt_h2f_q;
        RG_CTRL: f_reg_q <= f_ctl_view;
        RG_MASK: f_reg_q <= mask_q;
        default: f_reg_q <= '0;
      endcase
    end
  end

  assign h_rdata = h_isbuf_q ? h_buf_rd : h_reg_q;
  assign f_rdata = f_isbuf_q ? f_buf_rd : f_reg_q;

  // ---------------- doorbell and read-complete ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      h_req_d     <= 1'b0;
      fw_doorbell <= 1'b0;
      fw_rd_done  <= 1'b0;
    end else begin
      h_req_d     <= h_req;
      fw_doorbell <= h_req & ~h_req_d & ~mask_q[0];
      fw_rd_done  <= h_bw && (h_bidx == '0);
    end
  end

  AST_DB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fw_doorbell |=> !fw_doorbell); // R7

  AST_DB_MASKED: assert property (@(posedge clk) disable iff (rst)
    fw_doorbell |-> !$past(mask_q[0])); // R8

  AST_F2H_HOST_RO: assert property (@(posedge clk) disable iff (rst)
    !(f_wr && f_rg == RG_F2H) |=> $stable(cnt_f2h_q)); // R2

  AST_RD_DONE_OWNED: assert property (@(posedge clk) disable iff (rst)
    fw_rd_done |-> $past(h_hold)); // R9

endmodule

// File: tb/mbox_bank_test.sv
module mbox_bank_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_F2H  = 5'd0;
  localparam logic [AW-1:0] A_H2F  = 5'd1;
  localparam logic [AW-1:0] A_B0   = 5'd2;
  localparam logic [AW-1:0] A_B1   = 5'd3;
  localparam logic [AW-1:0] A_B2   = 5'd4;
  localparam logic [AW-1:0] A_BL   = 5'd15;
  localparam logic [AW-1:0] A_CTL  = 5'd16;
  localparam logic [AW-1:0] A_MASK = 5'd17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          h_wr = 1'b0, f_wr = 1'b0;
  logic [AW-1:0] h_addr = '0, f_addr = '0;
  logic [DW-1:0] h_wdata = '0, f_wdata = '0;
  logic [DW-1:0] h_rdata, f_rdata;
  logic          fw_doorbell, fw_rd_done;

  int tests_run = 0;
  int tests_failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_bank uut (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .f_wr(f_wr), .f_addr(f_addr), .f_wdata(f_wdata), .f_rdata(f_rdata),
    .fw_doorbell(fw_doorbell), .fw_rd_done(fw_rd_done)
  );

  task automatic check(input string req, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic hwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic fwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    f_wr = 1'b1; f_addr = a; f_wdata = d;
    @(negedge clk);
    f_wr = 1'b0;
  endtask

  task automatic both_wr(input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                         input logic [AW-1:0] fa, input logic [DW-1:0] fd);
    h_wr = 1'b1; h_addr = ha; h_wdata = hd;
    f_wr = 1'b1; f_addr = fa; f_wdata = fd;
    @(negedge clk);
    h_wr = 1'b0; f_wr = 1'b0;
  endtask

  task automatic hrd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    h_addr = a;
    @(negedge clk);
    v = h_rdata;
  endtask

  task automatic frd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    f_addr = a;
    @(negedge clk);
    v = f_rdata;
  endtask

  // doorbell after a host control write: low now, then expect pulse pattern
  task automatic db_watch(input string req, input logic exp_pulse);
    check(req, "doorbell at write edge", {31'd0, fw_doorbell}, 32'd0);
    @(negedge clk);
    check(req, "doorbell next cycle", {31'd0, fw_doorbell}, {31'd0, exp_pulse});
    @(negedge clk);
    check(req, "doorbell after pulse", {31'd0, fw_doorbell}, 32'd0);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "doorbell idle", {31'd0, fw_doorbell}, 32'd0);
    check("R1", "rd_done idle", {31'd0, fw_rd_done}, 32'd0);
    hrd(A_F2H, v);  check("R1", "f2h word", v, 32'd0);
    hrd(A_H2F, v);  check("R1", "h2f word", v, 32'd0);
    hrd(A_CTL, v);  check("R1", "host ctrl", v, 32'd0);
    frd(A_CTL, v);  check("R1", "fw ctrl", v, 32'd0);
    hrd(A_MASK, v); check("R8", "mask reset", v, 32'hFFFF_0000);
  endtask

  task automatic t_counters();
    logic [DW-1:0] v;
    hwr(A_H2F, 32'h0003_0007);
    frd(A_H2F, v); check("R2", "h2f seen by fw", v, 32'h0003_0007);
    check("R10", "one-cycle read latency", v, 32'h0003_0007);
    hwr(A_F2H, 32'h0000_DEAD);
    hrd(A_F2H, v); check("R2", "host write to f2h ignored", v, 32'd0);
    fwr(A_F2H, 32'h0001_0002);
    hrd(A_F2H, v); check("R2", "f2h seen by host", v, 32'h0001_0002);
    fwr(A_H2F, 32'hFFFF_FFFF);
    hrd(A_H2F, v); check("R2", "fw write to h2f ignored", v, 32'h0003_0007);
  endtask

  task automatic t_host_lock();
    logic [DW-1:0] v;
    hwr(A_CTL, 32'h8);
    hrd(A_CTL, v); check("R4", "host hold granted", v, 32'h8);
    frd(A_CTL, v); check("R4", "fw sees host hold", v, 32'h10);
    hwr(A_B1, 32'h0000_0033);
    check("R9", "no rd_done on other word", {31'd0, fw_rd_done}, 32'd0);
    hwr(A_B0, 32'h1111_1111);
    check("R9", "rd_done pulse", {31'd0, fw_rd_done}, 32'd1);
    @(negedge clk);
    check("R9", "rd_done one cycle", {31'd0, fw_rd_done}, 32'd0);
    hwr(A_BL, 32'h0000_ABCD);
    frd(A_B0, v); check("R3", "fw reads buf word 0", v, 32'h1111_1111);
    frd(A_BL, v); check("R3", "fw reads last buf word", v, 32'h0000_ABCD);
    fwr(A_B1, 32'h0000_0BAD);
    hrd(A_B1, v); check("R3", "fw write without lock ignored", v, 32'h0000_0033);
    fwr(A_CTL, 32'h8);
    frd(A_CTL, v); check("R5", "fw denied while host holds", v, 32'h10);
  endtask

  task automatic t_request_release();
    logic [DW-1:0] v;
    hwr(A_CTL, 32'h9);
    db_watch("R7", 1'b1);
    hrd(A_CTL, v); check("R7", "request stored", v, 32'h9);
    hwr(A_CTL, 32'h9);
    db_watch("R7", 1'b0);
    hwr(A_CTL, 32'h0);
    hrd(A_CTL, v); check("R6", "release clears hold and req", v, 32'h0);
    hwr(A_B0, 32'h5555_5555);
    check("R9", "no rd_done without lock", {31'd0, fw_rd_done}, 32'd0);
    frd(A_B0, v); check("R3", "host write after release ignored", v, 32'h1111_1111);
  endtask

  task automatic t_conflict();
    logic [DW-1:0] v;
    both_wr(A_CTL, 32'h8, A_CTL, 32'h8);
    frd(A_CTL, v); check("R5", "fw wins tie", v, 32'h8);
    hrd(A_CTL, v); check("R5", "host loses tie", v, 32'h10);
    fwr(A_B2, 32'h0000_0044);
    hrd(A_B2, v); check("R3", "fw write with lock", v, 32'h0000_0044);
    hwr(A_CTL, 32'h9);
    db_watch("R7", 1'b0);
    hrd(A_CTL, v); check("R7", "no req without hold", v, 32'h10);
    fwr(A_CTL, 32'h0);
    frd(A_CTL, v); check("R6", "fw release", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    hwr(A_MASK, 32'h1);
    hrd(A_MASK, v); check("R8", "host mask write", v, 32'h1);
    hwr(A_CTL, 32'h9);
    db_watch("R8", 1'b0);
    hwr(A_CTL, 32'h0);
    both_wr(A_MASK, 32'h1, A_MASK, 32'hFFFF_0000);
    frd(A_MASK, v); check("R8", "fw mask write wins", v, 32'hFFFF_0000);
    hwr(A_CTL, 32'h9);
    db_watch("R8", 1'b1);
    hwr(A_CTL, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_counters();
    t_host_lock();
    t_request_release();
    t_conflict();
    t_mask();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule